// File: doc/BRIEF.md
# Local-Bus Endian Converter for DMA Longwords

This block sits between a 32-bit local-bus port and the FIFO that feeds a little-endian PCI-side engine. It carries longword data in both directions. Words read from the local bus travel toward the FIFO. Words popped from the FIFO travel toward the local bus. The block reorders byte lanes only when the local bus has been strapped big endian. All DMA traffic on this path is longword-sized.

The local-bus byte order is captured from a strap pin while reset is held. It then stays fixed until the next reset. Four per-channel mode registers each hold a 2-bit alignment mode:

| Mode | Treatment of the longword | Lane mapping |
|------|---------------------------|--------------|
| 00 | Byte-boundary data | Full byte reversal |
| 01 | Four separate byte units | Full byte reversal |
| 10 | Two halfword units | The two halfwords change places |
| 11 | One 32-bit unit | Unchanged |

A transfer-start pulse copies the selected channel's mode into an active-mode register. Both directions then use that register until the next pulse. Each direction has one output register with a valid/ready handshake, so a beat emerges one cycle after it is accepted.

Top module: `lbus_endian_bridge`

## Requirements
- R1: While reset is held and in the cycle after it is released, `fifoPushValid` and `lbWrValid` are 0, and `lbRdReady` and `fifoPopReady` are 1.
- R2: With the strap captured as 0 (little endian), both directions deliver every accepted word unchanged, whatever the active mode.
- R3: With the strap captured as 1 (big endian) and active mode 00 or 01, a word's output byte lane k (bits 8k+7:8k) equals its input byte lane 3-k, in both directions.
- R4: With the strap captured as 1 and active mode 10, the output's bits 31:16 equal the input's bits 15:0, and the output's bits 15:0 equal the input's bits 31:16. Byte order inside each halfword is kept.
- R5: With the strap captured as 1 and active mode 11, words pass unchanged.
- R6: `strapBigEnd` is sampled on every clock edge at which `rstN` is low. Changes to it while `rstN` is high have no effect on the data.
- R7: A cycle with `cfgWrEn` high writes `cfgMode` into the mode register of channel `cfgChan`. All four registers reset to 00.
- R8: A cycle with `xferStart` high loads the mode register of channel `chanSel` into the active mode, which resets to 00. The value loaded is the one stored before any write in that same cycle. A word accepted in that same cycle is still converted with the previous active mode.
- R9: Per direction, a word accepted on an edge (input valid and ready) is presented at the output from the next cycle. The input ready is high whenever the output register is empty or the downstream side is ready. No word is lost, duplicated or reordered.
- R10: While an output is valid and its ready is low, the output's valid and data hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; the strap is sampled while it is low |
| strapBigEnd | input | 1 | Byte-order strap: 1 = local bus big endian |
| cfgWrEn | input | 1 | Write strobe for a channel mode register |
| cfgChan | input | 2 | Channel addressed by the write |
| cfgMode | input | 2 | Mode value written |
| chanSel | input | 2 | Channel whose mode a transfer start loads |
| xferStart | input | 1 | Transfer start: loads the active mode |
| lbRdValid | input | 1 | Local-bus read word valid |
| lbRdReady | output | 1 | Converter can take a local-bus read word |
| lbRdData | input | 32 | Local-bus read word |
| fifoPushValid | output | 1 | Converted word toward the FIFO is valid |
| fifoPushReady | input | 1 | FIFO accepts the word |
| fifoPushData | output | 32 | Converted word toward the FIFO |
| fifoPopValid | input | 1 | FIFO word valid |
| fifoPopReady | output | 1 | Converter can take a FIFO word |
| fifoPopData | input | 32 | FIFO word |
| lbWrValid | output | 1 | Converted word toward the local bus is valid |
| lbWrReady | input | 1 | Local bus accepts the word |
| lbWrData | output | 32 | Converted word toward the local bus |

## Verification
Two events can land on the same edge: a transfer start that changes the active mode, and a word being accepted in either direction. A channel write and a start on that same channel can also coincide. The stimulus raises `xferStart`, `cfgWrEn` and both input valids at random, often together. It also includes a directed cycle that writes and starts the same channel at once. The bench model applies the accepted word with the old mode before updating the mode registers, so each output word is judged against the mode that R8 assigns to it. Random stalls on both outputs also test the hold behaviour at the same time.

// File: rtl/endian_bridge_pkg.sv
`timescale 1ns/1ps
package endian_bridge_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_BYTE_BOUND = 2'b00,
    MODE_BYTE_UNITS = 2'b01,
    MODE_HALF_UNITS = 2'b10,
    MODE_WORD_UNIT  = 2'b11
  } align_mode_e;

  // Strobes from control to the datapath lanes
  typedef struct packed {
    logic bigEnd;
    logic swapBytes;
    logic swapHalves;
  } conv_strobe_t;
endpackage

// File: rtl/endian_ctrl.sv
`timescale 1ns/1ps
module endian_ctrl
  import endian_bridge_pkg::*;
#(
  parameter int CHANS  = 4,
  localparam int CHAN_W = (CHANS > 1) ? $clog2(CHANS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapBigEnd,
  input  logic              cfgWrEn,
  input  logic [CHAN_W-1:0] cfgChan,
  input  logic [MODE_W-1:0] cfgMode,
  input  logic [CHAN_W-1:0] chanSel,
  input  logic              xferStart,
  output conv_strobe_t      strobes
);
  logic        bigEnd;
  align_mode_e activeMode;
  logic [MODE_W-1:0] chanMode [CHANS];

  // Strap is captured on every edge that sees reset asserted, then frozen
  always_ff @(posedge clk) begin
    if (!rstN) bigEnd <= strapBigEnd;
  end

  for (genvar g = 0; g < CHANS; g++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                     chanMode[g] <= '0;
      else if (cfgWrEn && (cfgChan == CHAN_W'(g)))   chanMode[g] <= cfgMode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          activeMode <= MODE_BYTE_BOUND;
    else if (xferStart) activeMode <= align_mode_e'(chanMode[chanSel]);
  end

  always_comb begin
    strobes.bigEnd     = bigEnd;
    strobes.swapBytes  = bigEnd && ((activeMode == MODE_BYTE_BOUND) ||
                                    (activeMode == MODE_BYTE_UNITS));
    strobes.swapHalves = bigEnd && (activeMode == MODE_HALF_UNITS);
  end
endmodule

// File: rtl/endian_lane_path.sv
`timescale 1ns/1ps
module endian_lane_path #(
  parameter int DATA_W = 32,
  localparam int NB   = DATA_W / 8,
  localparam int HALF = NB / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swapBytes,
  input  logic              swapHalves,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData
);
  logic [DATA_W-1:0] swapped;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam int REV = NB - 1 - i;
    localparam int HSW = (i + HALF) % NB;
    assign swapped[i*8 +: 8] = swapBytes  ? inData[REV*8 +: 8] :
                               swapHalves ? inData[HSW*8 +: 8] :
                                            inData[i*8 +: 8];
  end

  assign inReady = !outValid || outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else if (inReady) begin
      outValid <= inValid;
      if (inValid) outData <= swapped;
    end
  end
endmodule

// File: rtl/lbus_endian_bridge.sv
`timescale 1ns/1ps
module lbus_endian_bridge
  import endian_bridge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHANS  = 4,
  localparam int CHAN_W = (CHANS > 1) ? $clog2(CHANS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapBigEnd,
  input  logic              cfgWrEn,
  input  logic [CHAN_W-1:0] cfgChan,
  input  logic [MODE_W-1:0] cfgMode,
  input  logic [CHAN_W-1:0] chanSel,
  input  logic              xferStart,
  input  logic              lbRdValid,
  output logic              lbRdReady,
  input  logic [DATA_W-1:0] lbRdData,
  output logic              fifoPushValid,
  input  logic              fifoPushReady,
  output logic [DATA_W-1:0] fifoPushData,
  input  logic              fifoPopValid,
  output logic              fifoPopReady,
  input  logic [DATA_W-1:0] fifoPopData,
  output logic              lbWrValid,
  input  logic              lbWrReady,
  output logic [DATA_W-1:0] lbWrData
);
  conv_strobe_t strobes;

  endian_ctrl #(.CHANS(CHANS)) u_ctrl (
    .clk, .rstN, .strapBigEnd, .cfgWrEn, .cfgChan, .cfgMode,
    .chanSel, .xferStart, .strobes
  );

  endian_lane_path #(.DATA_W(DATA_W)) u_toFifo (
    .clk, .rstN,
    .swapBytes(strobes.swapBytes), .swapHalves(strobes.swapHalves),
    .inValid(lbRdValid), .inReady(lbRdReady), .inData(lbRdData),
    .outValid(fifoPushValid), .outReady(fifoPushReady), .outData(fifoPushData)
  );

  endian_lane_path #(.DATA_W(DATA_W)) u_toLbus (
    .clk, .rstN,
    .swapBytes(strobes.swapBytes), .swapHalves(strobes.swapHalves),
    .inValid(fifoPopValid), .inReady(fifoPopReady), .inData(fifoPopData),
    .outValid(lbWrValid), .outReady(lbWrReady), .outData(lbWrData)
  );
endmodule

// File: rtl/lbus_endian_bridge_checker.sv
`timescale 1ns/1ps
module lbus_endian_bridge_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              bigEnd,
  input logic              lbRdValid,
  input logic              lbRdReady,
  input logic [DATA_W-1:0] lbRdData,
  input logic              fifoPushValid,
  input logic              fifoPushReady,
  input logic [DATA_W-1:0] fifoPushData,
  input logic              fifoPopValid,
  input logic              fifoPopReady,
  input logic [DATA_W-1:0] fifoPopData,
  input logic              lbWrValid,
  input logic              lbWrReady,
  input logic [DATA_W-1:0] lbWrData
);
  a_r6_strap_locked: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(bigEnd));

  a_r9_push_follows_accept: assert property (@(posedge clk) disable iff (!rstN)
    (lbRdValid && lbRdReady) |=> fifoPushValid);

  a_r9_wr_follows_accept: assert property (@(posedge clk) disable iff (!rstN)
    (fifoPopValid && fifoPopReady) |=> lbWrValid);

  a_r9_no_spurious_push: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fifoPushValid) |-> $past(lbRdValid && lbRdReady));

  a_r10_push_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fifoPushValid && !fifoPushReady) |=> (fifoPushValid && $stable(fifoPushData)));

  a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (lbWrValid && !lbWrReady) |=> (lbWrValid && $stable(lbWrData)));

  a_r2_little_pass_rd: assert property (@(posedge clk) disable iff (!rstN)
    (!bigEnd && lbRdValid && lbRdReady) |=> (fifoPushData == $past(lbRdData)));

  a_r2_little_pass_wr: assert property (@(posedge clk) disable iff (!rstN)
    (!bigEnd && fifoPopValid && fifoPopReady) |=> (lbWrData == $past(fifoPopData)));
endmodule

bind lbus_endian_bridge lbus_endian_bridge_checker #(.DATA_W(DATA_W)) u_chk (
  .clk, .rstN, .bigEnd(strobes.bigEnd),
  .lbRdValid, .lbRdReady, .lbRdData,
  .fifoPushValid, .fifoPushReady, .fifoPushData,
  .fifoPopValid, .fifoPopReady, .fifoPopData,
  .lbWrValid, .lbWrReady, .lbWrData
);

// File: tb/lbus_endian_bridge_bench.sv
`timescale 1ns/1ps
module lbus_endian_bridge_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strapBigEnd = 1'b0;
  logic cfgWrEn = 1'b0, xferStart = 1'b0;
  logic [1:0] cfgChan = '0, cfgMode = '0, chanSel = '0;
  logic lbRdValid = 1'b0, fifoPushReady = 1'b0, fifoPopValid = 1'b0, lbWrReady = 1'b0;
  logic [31:0] lbRdData = '0, fifoPopData = '0;
  logic lbRdReady, fifoPushValid, fifoPopReady, lbWrValid;
  logic [31:0] fifoPushData, lbWrData;

  int compared = 0, mismatched = 0;

  bit         mBig;
  logic [1:0] mChan [4];
  logic [1:0] mActive;
  logic [31:0] qPush[$], qWr[$];
  string       tPush[$], tWr[$];
  bit          stallPush = 0, stallWr = 0;
  logic [31:0] heldPush, heldWr;

  always #5 clk = ~clk;

  lbus_endian_bridge u_lbus_endian_bridge (.*);

  function automatic logic [31:0] expConv(input bit big, input logic [1:0] m, input logic [31:0] d);
    if (!big || m == 2'b11) return d;
    if (m == 2'b10) return {d[15:0], d[31:16]};
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic string tagFor(input bit big, input logic [1:0] m);
    if (!big) return "R2 (R6 R9)";
    if (m == 2'b10) return "R4 (R7 R8 R9)";
    if (m == 2'b11) return "R5 (R7 R8 R9)";
    return "R3 (R7 R8 R9)";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // Called #1 after inputs change at a negedge: evaluates what the next posedge does
  task automatic observe();
    if (stallPush) check("R10 push hold", {31'd0, fifoPushValid} ^ 32'd0 | (fifoPushData ^ heldPush), 32'd1);
    if (stallWr)   check("R10 wr hold",   {31'd0, lbWrValid} | (lbWrData ^ heldWr), 32'd1);
    stallPush = fifoPushValid && !fifoPushReady; heldPush = fifoPushData;
    stallWr   = lbWrValid && !lbWrReady;         heldWr   = lbWrData;
    if (fifoPushValid && fifoPushReady) begin
      if (qPush.size() == 0) check("R9 push unexpected", 32'd1, 32'd0);
      else check(tPush.pop_front(), fifoPushData, qPush.pop_front());
    end
    if (lbWrValid && lbWrReady) begin
      if (qWr.size() == 0) check("R9 wr unexpected", 32'd1, 32'd0);
      else check(tWr.pop_front(), lbWrData, qWr.pop_front());
    end
    check("R9 rd ready", {31'd0, lbRdReady}, {31'd0, !fifoPushValid || fifoPushReady});
    if (lbRdValid && lbRdReady) begin
      qPush.push_back(expConv(mBig, mActive, lbRdData));
      tPush.push_back(tagFor(mBig, mActive));
    end
    if (fifoPopValid && fifoPopReady) begin
      qWr.push_back(expConv(mBig, mActive, fifoPopData));
      tWr.push_back(tagFor(mBig, mActive));
    end
    begin
      logic [1:0] nextActive = xferStart ? mChan[chanSel] : mActive;
      if (cfgWrEn) mChan[cfgChan] = cfgMode;
      mActive = nextActive;
    end
  endtask

  task automatic idleInputs();
    cfgWrEn = 0; xferStart = 0; lbRdValid = 0; fifoPopValid = 0;
  endtask

  task automatic step();
    #1 observe();
    @(negedge clk);
  endtask

  task automatic runPhase(input bit strap, input int cycles);
    @(negedge clk);
    rstN = 0; strapBigEnd = strap; idleInputs();
    fifoPushReady = 1; lbWrReady = 1;
    qPush.delete(); qWr.delete(); tPush.delete(); tWr.delete();
    stallPush = 0; stallWr = 0;
    repeat (3) @(negedge clk);
    check("R1 push valid in reset", {31'd0, fifoPushValid}, 32'd0);
    check("R1 wr valid in reset",   {31'd0, lbWrValid}, 32'd0);
    check("R1 readies in reset",    {30'd0, lbRdReady, fifoPopReady}, 32'd3);
    mBig = strap; mActive = 2'b00;
    for (int c = 0; c < 4; c++) mChan[c] = 2'b00;
    rstN = 1;
    @(negedge clk);
    check("R1 push valid after reset", {31'd0, fifoPushValid}, 32'd0);
    check("R1 readies after reset",    {30'd0, lbRdReady, fifoPopReady}, 32'd3);
    // R7/R8 directed: word accepted with reset mode 00, then per-channel modes
    for (int c = 0; c < 4; c++) begin
      cfgWrEn = 1; cfgChan = 2'(c); cfgMode = 2'(3 - c);
      lbRdValid = 1; lbRdData = 32'h1122_3344 + 32'(c);
      fifoPopValid = 1; fifoPopData = 32'hA1B2_C3D4 ^ 32'(c);
      step();
    end
    for (int c = 0; c < 4; c++) begin
      cfgWrEn = 0; xferStart = 1; chanSel = 2'(c); step();
      xferStart = 0; lbRdData = 32'hDEAD_BEEF; fifoPopData = 32'h0102_0304; step();
    end
    // R8 corner: write and start on the same channel in one cycle
    cfgWrEn = 1; cfgChan = 2'd1; cfgMode = 2'b11; xferStart = 1; chanSel = 2'd1;
    lbRdData = 32'hCAFE_F00D; step();
    idleInputs(); lbRdValid = 1; lbRdData = 32'h5566_7788; step();
    xferStart = 1; step();
    xferStart = 0; lbRdData = 32'h99AA_BBCC; step();
    // Random mix, strap wiggled to show R6
    for (int n = 0; n < cycles; n++) begin
      strapBigEnd   = 1'($urandom);
      cfgWrEn       = ($urandom % 8) == 0;
      cfgChan       = 2'($urandom); cfgMode = 2'($urandom);
      xferStart     = ($urandom % 6) == 0;
      chanSel       = 2'($urandom);
      lbRdValid     = ($urandom % 4) != 0; lbRdData    = $urandom;
      fifoPopValid  = ($urandom % 3) != 0; fifoPopData = $urandom;
      fifoPushReady = ($urandom % 3) != 0;
      lbWrReady     = ($urandom % 4) != 0;
      step();
    end
    idleInputs(); fifoPushReady = 1; lbWrReady = 1;
    repeat (4) step();
    check("R9 push drained", 32'(qPush.size()), 32'd0);
    check("R9 wr drained",   32'(qWr.size()), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    runPhase(1'b1, 4000);
    runPhase(1'b0, 2000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(1_500_000);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule